// File: doc/BRIEF.md
# Frame-Scheduled I2C Command Queue

This block holds 32-bit sensor I2C command words until a chosen video frame begins and then turns each word into a sequence of bus requests. The frame counter is 4 bits wide and advances on every frame-sync pulse. A command is written either to an absolute frame slot, where the slot index is the frame number modulo 16, or with a relative offset from the current frame. Offset 0 puts the command in an as-soon-as-possible queue.

Each command's top byte selects an entry in a page table. The entry says whether the command is a register write or a register read. It also gives the slave address and byte count for writes, and whether a read uses a one-byte or two-byte register address. The sequencer emits start, write-byte, read-byte and stop requests to a bit-level bus engine. It holds each request until the engine returns a done pulse. Writes longer than four bytes take their extra payload from the following words of the same slot, and those words skip the table.

Top module: `i2cq_frame_sched`

## Requirements
- R1: After reset, `req_valid` is 0, `overflow` is 0 and `frame_num` is 0.
- R2: Each cycle with `frame_sync` high increments `frame_num` by one, wrapping from 15 to 0.
- R3: With `cmd_abs`=1 a word goes to slot `cmd_slot`. With `cmd_abs`=0 and `cmd_slot` from 1 to 14 it goes to slot (`frame_num` + `cmd_slot`) mod 16, using `frame_num` as it stands at the write. A slot's commands are issued only while `frame_num` equals the slot index.
- R4: With `cmd_abs`=0 and `cmd_slot`=0 a word goes to the ASAP queue. The ASAP queue is served whenever the sequencer is idle and the current frame's slot is empty; the current frame's slot always wins.
- R5: A relative write with `cmd_slot`=15 is dropped and never issued.
- R6: Commands in one slot are issued in the order they were written.
- R7: A write command uses page `cmd[31:24]`. It issues START, then WRITE {slave,0}, then the lowest min(count,4) bytes of the word from the most significant of those down to byte 0, then STOP. With count 4 the page byte itself is sent as the high byte.
- R8: When count exceeds 4, the following words of the same slot are pure payload and are not looked up. Each sends its lowest min(remaining,4) bytes in descending order. Counts above 12 act as 12.
- R9: A read command issues START and WRITE {cmd[23:17],0}. It then issues WRITE cmd[15:8] only when the entry's two-byte flag is set, followed by WRITE cmd[7:0]. It then issues START, WRITE {cmd[23:17],1}, count READ requests (saturated at 12) and STOP.
- R10: A request stays valid with its kind and byte unchanged until `req_done`. The next request is presented only after that.
- R11: Each slot holds 8 words. A write to a full slot is dropped and sets `overflow`, which stays set until reset.
- R12: `req_kind` codes are 0 START, 1 WRITE, 2 READ and 3 STOP, and `req_byte` is 0 for all kinds except WRITE. A table entry is laid out as bit 12 read, bit 11 two-byte address, bits 10:4 slave address and bits 3:0 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle pulse at the start of each frame |
| cmd_we | input | 1 | Command word write strobe |
| cmd_abs | input | 1 | 1 = absolute slot, 0 = relative offset |
| cmd_slot | input | 4 | Absolute slot or relative offset |
| cmd_data | input | 32 | Command or continuation word |
| tbl_we | input | 1 | Page table write strobe |
| tbl_page | input | 8 | Page table entry index |
| tbl_wdata | input | 13 | Page table entry value |
| req_valid | output | 1 | Bus request present |
| req_kind | output | 2 | Request kind code |
| req_byte | output | 8 | Byte to send for WRITE requests |
| req_done | input | 1 | Bus engine has completed the request |
| overflow | output | 1 | Sticky slot overflow flag |
| frame_num | output | 4 | Current frame number modulo 16 |

## Verification
The hardest case to reach is the priority check between the current frame's slot and the ASAP queue. Both must hold work while the sequencer is busy. The bench does this by withholding `req_done` from its bus responder, which parks the sequencer on its first START. It then queues an ASAP command and a current-frame command before releasing the responder. Continuation words are also written one at a time, so the sequencer regularly waits for them to arrive. A sweep over every table count from 0 to 15 covers the trimming and saturation rules.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
   localparam int PAGE_W    = 8;
   localparam int CNT_W     = 4;
   localparam int MAX_BYTES = 12;
   localparam int ENT_W     = 2 + 7 + CNT_W;

   typedef enum logic [1:0] {
      K_START = 2'd0,
      K_WRITE = 2'd1,
      K_READ  = 2'd2,
      K_STOP  = 2'd3
   } req_kind_e;

   typedef struct packed {
      logic             rd;
      logic             addr2;
      logic [6:0]       slave;
      logic [CNT_W-1:0] cnt;
   } page_ent_t;

   typedef enum logic [3:0] {
      S_IDLE, S_DECODE, S_START, S_SLAVE, S_WBYTE, S_FETCH,
      S_RADDR, S_RSTART, S_RSLAVE, S_RDATA, S_STOP
   } seq_state_e;
endpackage

// File: rtl/i2cq_slot_fifo.sv
module i2cq_slot_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("slot depth must be a power of two of at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R11: occupancy never passes the slot depth
   a_r11_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH));
   // R6: the sequencer never pops an empty slot
   a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/i2cq_page_table.sv
module i2cq_page_table
   import i2cq_pkg::*;
#(
   parameter int AW = PAGE_W
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  page_ent_t     wdata,
   input  logic [AW-1:0] raddr,
   output page_ent_t     rdata
);
   page_ent_t tbl [2**AW];

   always_ff @(posedge clk) begin
      if (we) tbl[waddr] <= wdata;
   end

   assign rdata = tbl[raddr];
endmodule

// File: rtl/i2cq_byte_seq.sv
module i2cq_byte_seq
   import i2cq_pkg::*;
#(
   parameter int NQ      = 17,
   parameter int SEL_W   = 5,
   parameter int FRAME_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [FRAME_W-1:0]     frame_idx,
   input  logic [NQ-1:0]          q_empty,
   input  logic [NQ-1:0][31:0]    q_head,
   output logic [NQ-1:0]          q_pop,
   output logic [PAGE_W-1:0]      tbl_page,
   input  page_ent_t              tbl_ent,
   output logic                   req_valid,
   output logic [1:0]             req_kind,
   output logic [7:0]             req_byte,
   input  logic                   req_done
);
   localparam int ASAP_IDX = NQ - 1;

   seq_state_e       st;
   logic [SEL_W-1:0] src, pick;
   logic             pick_ok;
   logic [31:0]      word;
   logic [1:0]       ptr;
   logic [CNT_W-1:0] left, eff;
   page_ent_t        ent;
   logic             acc;
   logic [7:0]       cur_byte;

   assign tbl_page = word[31 -: PAGE_W];
   assign eff      = (tbl_ent.cnt > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : tbl_ent.cnt;
   assign cur_byte = word[{ptr, 3'b000} +: 8];
   assign acc      = req_valid && req_done;

   always_comb begin
      pick_ok = 1'b0;
      pick    = '0;
      if (!q_empty[frame_idx]) begin
         pick_ok = 1'b1;
         pick    = SEL_W'(frame_idx);
      end else if (!q_empty[ASAP_IDX]) begin
         pick_ok = 1'b1;
         pick    = SEL_W'(ASAP_IDX);
      end
      q_pop = '0;
      if (st == S_IDLE && pick_ok)              q_pop[pick] = 1'b1;
      else if (st == S_FETCH && !q_empty[src])  q_pop[src]  = 1'b1;
   end

   always_comb begin
      req_valid = 1'b1;
      req_kind  = K_WRITE;
      req_byte  = 8'h00;
      case (st)
         S_START, S_RSTART: req_kind = K_START;
         S_SLAVE:           req_byte = ent.rd ? {word[23:17], 1'b0} : {ent.slave, 1'b0};
         S_WBYTE, S_RADDR:  req_byte = cur_byte;
         S_RSLAVE:          req_byte = {word[23:17], 1'b1};
         S_RDATA:           req_kind = K_READ;
         S_STOP:            req_kind = K_STOP;
         default:           req_valid = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         src  <= '0;
         word <= '0;
         ptr  <= '0;
         left <= '0;
         ent  <= '0;
      end else begin
         case (st)
            S_IDLE: if (pick_ok) begin
               src  <= pick;
               word <= q_head[pick];
               st   <= S_DECODE;
            end
            S_DECODE: begin
               ent  <= tbl_ent;
               left <= eff;
               if (tbl_ent.rd)           ptr <= tbl_ent.addr2 ? 2'd1 : 2'd0;
               else if (eff >= 4'd4)     ptr <= 2'd3;
               else                      ptr <= 2'(eff - 1'b1);
               st   <= S_START;
            end
            S_START: if (acc) st <= S_SLAVE;
            S_SLAVE: if (acc) begin
               if (ent.rd)            st <= S_RADDR;
               else if (left == '0)   st <= S_STOP;
               else                   st <= S_WBYTE;
            end
            S_WBYTE: if (acc) begin
               left <= left - 1'b1;
               if (ptr != 2'd0)       ptr <= ptr - 1'b1;
               else if (left == 4'd1) st  <= S_STOP;
               else                   st  <= S_FETCH;
            end
            S_FETCH: if (!q_empty[src]) begin
               word <= q_head[src];
               ptr  <= (left >= 4'd4) ? 2'd3 : 2'(left - 1'b1);
               st   <= S_WBYTE;
            end
            S_RADDR: if (acc) begin
               if (ptr == 2'd0) st  <= S_RSTART;
               else             ptr <= ptr - 1'b1;
            end
            S_RSTART: if (acc) st <= S_RSLAVE;
            S_RSLAVE: if (acc) st <= (left == '0) ? S_STOP : S_RDATA;
            S_RDATA: if (acc) begin
               left <= left - 1'b1;
               if (left == 4'd1) st <= S_STOP;
            end
            S_STOP: if (acc) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R10: an unanswered request is held unchanged
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_done) |=> (req_valid && $stable(req_kind) && $stable(req_byte)));
   // R7: every command opens with a START request
   a_r7_start_first: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DECODE) |=> (req_valid && req_kind == K_START));
endmodule

// File: rtl/i2cq_frame_sched.sv
module i2cq_frame_sched
   import i2cq_pkg::*;
#(
   parameter int FRAME_W    = 4,
   parameter int SLOT_DEPTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_sync,
   input  logic               cmd_we,
   input  logic               cmd_abs,
   input  logic [FRAME_W-1:0] cmd_slot,
   input  logic [31:0]        cmd_data,
   input  logic               tbl_we,
   input  logic [PAGE_W-1:0]  tbl_page,
   input  logic [ENT_W-1:0]   tbl_wdata,
   output logic               req_valid,
   output logic [1:0]         req_kind,
   output logic [7:0]         req_byte,
   input  logic               req_done,
   output logic               overflow,
   output logic [FRAME_W-1:0] frame_num
);
   localparam int NFRAMES  = 2 ** FRAME_W;
   localparam int NQ       = NFRAMES + 1;
   localparam int ASAP_IDX = NFRAMES;
   localparam int SEL_W    = $clog2(NQ);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("frame counter needs at least two bits");
   end

   logic [NQ-1:0]        q_push, q_pop, q_empty, q_full;
   logic [NQ-1:0][31:0]  q_head;
   logic [SEL_W-1:0]     tgt;
   logic                 tgt_ok;
   logic [PAGE_W-1:0]    rd_page;
   page_ent_t            rd_ent;

   always_comb begin
      tgt    = '0;
      tgt_ok = 1'b0;
      if (cmd_abs) begin
         tgt    = SEL_W'(cmd_slot);
         tgt_ok = 1'b1;
      end else if (cmd_slot == '0) begin
         tgt    = SEL_W'(ASAP_IDX);
         tgt_ok = 1'b1;
      end else if (cmd_slot != '1) begin
         tgt    = SEL_W'(FRAME_W'(frame_num + cmd_slot));
         tgt_ok = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_num <= '0;
         overflow  <= 1'b0;
      end else begin
         if (frame_sync) frame_num <= frame_num + 1'b1;
         if (cmd_we && tgt_ok && q_full[tgt]) overflow <= 1'b1;
      end
   end

   for (genvar i = 0; i < NQ; i++) begin : g_q
      assign q_push[i] = cmd_we && tgt_ok && (tgt == SEL_W'(i));
      i2cq_slot_fifo #(.DW(32), .DEPTH(SLOT_DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (q_push[i]),
         .din   (cmd_data),
         .pop   (q_pop[i]),
         .head  (q_head[i]),
         .empty (q_empty[i]),
         .full  (q_full[i])
      );
   end

   i2cq_page_table #(.AW(PAGE_W)) u_tbl (
      .clk   (clk),
      .we    (tbl_we),
      .waddr (tbl_page),
      .wdata (page_ent_t'(tbl_wdata)),
      .raddr (rd_page),
      .rdata (rd_ent)
   );

   i2cq_byte_seq #(.NQ(NQ), .SEL_W(SEL_W), .FRAME_W(FRAME_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_idx (frame_num),
      .q_empty   (q_empty),
      .q_head    (q_head),
      .q_pop     (q_pop),
      .tbl_page  (rd_page),
      .tbl_ent   (rd_ent),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_byte  (req_byte),
      .req_done  (req_done)
   );

   // R2: the frame number steps by one per sync pulse
   a_r2_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> (frame_num == FRAME_W'($past(frame_num) + 1'b1)));
   // R11: the overflow flag never clears without reset
   a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

// File: tb/i2cq_frame_sched_bench.sv
module i2cq_frame_sched_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_sync = 1'b0;
   logic        cmd_we = 1'b0;
   logic        cmd_abs = 1'b0;
   logic [3:0]  cmd_slot = '0;
   logic [31:0] cmd_data = '0;
   logic        tbl_we = 1'b0;
   logic [7:0]  tbl_page = '0;
   logic [12:0] tbl_wdata = '0;
   logic        req_done = 1'b0;
   logic        req_valid, overflow;
   logic [1:0]  req_kind;
   logic [7:0]  req_byte;
   logic [3:0]  frame_num;

   int   n_vec = 0, n_bad = 0;
   logic [9:0] logv [0:511];
   logic [9:0] expv [0:511];
   int   log_n = 0, exp_n = 0;
   bit   hold = 1'b0;
   int   fr = 0;

   always #2 clk = ~clk;

   i2cq_frame_sched u_i2cq_frame_sched (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .cmd_we(cmd_we),
      .cmd_abs(cmd_abs), .cmd_slot(cmd_slot), .cmd_data(cmd_data),
      .tbl_we(tbl_we), .tbl_page(tbl_page), .tbl_wdata(tbl_wdata),
      .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
      .req_done(req_done), .overflow(overflow), .frame_num(frame_num)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expd);
      n_vec++;
      if (act !== expd) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
      end
   endtask

   task automatic responder();
      forever begin
         @(negedge clk);
         if (req_done) req_done = 1'b0;
         else if (req_valid && !hold) begin
            req_done = 1'b1;
            logv[log_n] = {req_kind, req_byte};
            log_n++;
         end
      end
   endtask

   function automatic logic [31:0] w0(input logic [7:0] page, input logic [7:0] s);
      return {page, s, ~s, s ^ 8'h3C};
   endfunction

   function automatic logic [31:0] cw(input logic [7:0] s, input int k);
      logic [7:0] kk;
      kk = 8'(k);
      return {s + 8'h10 * kk, s + 8'h20 * kk, s + 8'h40 * kk, s + 8'h80 * kk + kk};
   endfunction

   function automatic int sat(input int c);
      return (c > 12) ? 12 : c;
   endfunction

   task automatic put(input logic abs, input logic [3:0] slot, input logic [31:0] d);
      @(negedge clk);
      cmd_we = 1'b1; cmd_abs = abs; cmd_slot = slot; cmd_data = d;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic prog(input logic [7:0] page, input logic rd, input logic a2,
                       input logic [6:0] sl, input logic [3:0] c);
      @(negedge clk);
      tbl_we = 1'b1; tbl_page = page; tbl_wdata = {rd, a2, sl, c};
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic wcmd(input logic abs, input logic [3:0] slot, input logic [7:0] page,
                       input logic [7:0] s, input int c);
      int eff, nw;
      eff = sat(c);
      nw  = (eff > 4) ? (eff - 4 + 3) / 4 : 0;
      put(abs, slot, w0(page, s));
      for (int k = 1; k <= nw; k++) put(abs, slot, cw(s, k));
   endtask

   task automatic ex(input logic [1:0] k, input logic [7:0] b);
      expv[exp_n] = {k, b};
      exp_n++;
   endtask

   task automatic exp_write(input logic [6:0] sl, input int c, input logic [7:0] page,
                            input logic [7:0] s);
      int eff, n, rem;
      logic [31:0] w;
      eff = sat(c);
      n   = (eff > 4) ? 4 : eff;
      ex(2'd0, 8'h00);
      ex(2'd1, {sl, 1'b0});
      w = w0(page, s);
      for (int i = n - 1; i >= 0; i--) ex(2'd1, w[i*8 +: 8]);
      rem = eff - n;
      for (int k = 1; rem > 0; k++) begin
         int m;
         m = (rem > 4) ? 4 : rem;
         w = cw(s, k);
         for (int i = m - 1; i >= 0; i--) ex(2'd1, w[i*8 +: 8]);
         rem = rem - m;
      end
      ex(2'd3, 8'h00);
   endtask

   task automatic exp_read(input logic [31:0] c, input logic a2, input int cnt);
      ex(2'd0, 8'h00);
      ex(2'd1, {c[23:17], 1'b0});
      if (a2) ex(2'd1, c[15:8]);
      ex(2'd1, c[7:0]);
      ex(2'd0, 8'h00);
      ex(2'd1, {c[23:17], 1'b1});
      for (int i = 0; i < sat(cnt); i++) ex(2'd2, 8'h00);
      ex(2'd3, 8'h00);
   endtask

   task automatic settle(input string req);
      int t;
      t = 0;
      while (log_n < exp_n && t < 2000) begin
         @(negedge clk);
         t++;
      end
      repeat (8) @(negedge clk);
      chk({req, " request count"}, 32'(log_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < log_n; i++)
         chk({req, " request"}, {22'd0, logv[i]}, {22'd0, expv[i]});
      log_n = 0;
      exp_n = 0;
   endtask

   task automatic sync();
      @(negedge clk) frame_sync = 1'b1;
      @(negedge clk) frame_sync = 1'b0;
      fr = (fr + 1) % 16;
      chk("R2 frame number", {28'd0, frame_num}, 32'(fr));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      fork responder(); join_none
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req_valid", {31'd0, req_valid}, 0);
      chk("R1 overflow", {31'd0, overflow}, 0);
      chk("R1 frame_num", {28'd0, frame_num}, 0);

      // R7 R8 R12: write counts 0..15 through the ASAP queue
      for (int n = 0; n < 16; n++) begin
         logic [7:0] pg;
         logic [7:0] s;
         pg = 8'h40 + 8'(n);
         s  = 8'(n * 7 + 1);
         prog(pg, 1'b0, 1'b0, 7'(8'h20 + 8'(n)), 4'(n));
         wcmd(1'b0, 4'd0, pg, s, n);
         exp_write(7'(8'h20 + 8'(n)), n, pg, s);
         settle((n <= 4) ? "R7 R12 write" : "R8 R12 continuation");
      end

      // R9: reads with one- and two-byte register addresses
      for (int a2 = 0; a2 < 2; a2++) begin
         for (int c = 0; c < 4; c++) begin
            logic [7:0]  pg;
            logic [31:0] cmd;
            pg  = 8'h60 + 8'(a2 * 4 + c);
            cmd = {pg, 8'h90 + 8'(2 * c + a2), 8'hA0 + 8'(c), 8'h5C - 8'(c)};
            prog(pg, 1'b1, 1'(a2), 7'h7F, 4'(c));
            put(1'b0, 4'd0, cmd);
            exp_read(cmd, 1'(a2), c);
            settle("R9 read");
         end
      end

      // R3 R6: absolute and relative frame slots
      wcmd(1'b1, 4'((fr + 3) % 16), 8'h42, 8'd1, 2);
      wcmd(1'b1, 4'((fr + 3) % 16), 8'h42, 8'd2, 2);
      wcmd(1'b0, 4'd2, 8'h42, 8'd3, 2);
      settle("R3 nothing before its frame");
      sync();
      settle("R3 nothing one frame ahead");
      sync();
      exp_write(7'h22, 2, 8'h42, 8'd3);
      settle("R3 relative slot");
      sync();
      exp_write(7'h22, 2, 8'h42, 8'd1);
      exp_write(7'h22, 2, 8'h42, 8'd2);
      settle("R6 write order in slot");

      // R5: relative offset 15 is dropped
      put(1'b0, 4'd15, w0(8'h42, 8'd9));
      for (int i = 0; i < 17; i++) sync();
      settle("R5 offset 15 dropped");

      // R4 R10: frame slot beats the ASAP queue
      hold = 1'b1;
      wcmd(1'b0, 4'd0, 8'h42, 8'd10, 2);
      repeat (4) @(negedge clk);
      chk("R10 request held", {31'd0, req_valid}, 1);
      chk("R10 kind held", {30'd0, req_kind}, 0);
      wcmd(1'b0, 4'd0, 8'h42, 8'd11, 2);
      wcmd(1'b1, 4'(fr), 8'h42, 8'd12, 2);
      repeat (3) @(negedge clk);
      chk("R10 request still held", {31'd0, req_valid}, 1);
      chk("R10 nothing accepted", 32'(log_n), 0);
      hold = 1'b0;
      exp_write(7'h22, 2, 8'h42, 8'd10);
      exp_write(7'h22, 2, 8'h42, 8'd12);
      exp_write(7'h22, 2, 8'h42, 8'd11);
      settle("R4 priority");

      // R11: slot depth and sticky overflow
      begin
         logic [3:0] t;
         t = 4'((fr + 5) % 16);
         for (int i = 0; i < 8; i++) wcmd(1'b1, t, 8'h41, 8'(20 + i), 1);
         @(negedge clk);
         chk("R11 no overflow at depth", {31'd0, overflow}, 0);
         wcmd(1'b1, t, 8'h41, 8'd28, 1);
         @(negedge clk);
         chk("R11 overflow set", {31'd0, overflow}, 1);
         for (int i = 0; i < 5; i++) sync();
         for (int i = 0; i < 8; i++) exp_write(7'h21, 1, 8'h41, 8'(20 + i));
         settle("R11 ninth word dropped");
         chk("R11 overflow sticky", {31'd0, overflow}, 1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule